// File: doc/BRIEF.md
# Posted Hub Access Buffer

This block sits between one core's instruction pipeline and a shared memory that grants each core one access slot in turn. When the pipeline issues a load or store, the block takes it into a single holding register and lets the pipeline continue at once. The held request goes out to memory on the next slot the arbiter grants. The arbiter is not part of this block. It appears only as a one-cycle `slot_grant` pulse.

The pipeline is held back in only two cases. The first is a second load or store issued while the first is still held. The second is a "get" issued while a posted read has not yet returned its data. A read therefore works as a split pair: the request posts the address, and the get later collects the result, stalling only if the data is not there yet. Memory is always accessed as whole words. Byte and half-word reads pick their lane out of the fetched word. Byte and half-word writes are done as a read of the word followed, on the next slot, by a write of the merged word.

Top module: `hub_post_buf`

## Requirements
- R1: A request presented while the buffer is empty is accepted in that cycle without stall. Its memory access (`mem_strobe`) happens on the first `slot_grant` after the acceptance cycle, never in the acceptance cycle.
- R2: A request presented while an earlier one is still being processed raises `stall` combinationally in every cycle until the buffer is empty again. It is accepted in the first cycle in which `stall` is low.
- R3: The held request is never replaced. While a later request is stalled, `mem_addr` and `mem_wdata` keep the values of the held one.
- R4: `get_req` raises `stall` while a posted read has not delivered its data. For a read, `mem_rdata` is taken in the cycle after its slot, and `get_data` shows the result from the next cycle on.
- R5: `get_req` with no read outstanding does not stall. `get_data` keeps the most recent read result.
- R6: A full-word write uses one slot: `mem_strobe` and `mem_we` are high together, and `mem_wdata` equals the request data.
- R7: A byte or half-word write uses two slots. The first is a read (`mem_we` low). The second is a write of the word returned by that read, with only the addressed lane replaced. A byte lane is chosen by `req_addr[1:0]`, with lane 0 at bits 7:0. A half-word is chosen by `req_addr[1]`, with half 0 at bits 15:0. The low 8 or 16 bits of `req_wdata` are written.
- R8: A byte or half-word read returns the addressed lane of the fetched word, zero-extended, at bit 0 of `get_data`. Lanes are chosen as in R7.
- R9: `req_size` is 0 for a byte, 1 for a half-word, and 2 or 3 for a full word. `mem_addr` is `req_addr` with its two low bits dropped.
- R10: `mem_strobe` is never high without `slot_grant`, and a grant that arrives while the buffer is empty causes no access.
- R11: After reset `stall` and `mem_strobe` are low, `get_data` is zero and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Pipeline issues a load or store |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 full word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data, right-aligned for sub-word stores |
| get_req | input | 1 | Pipeline collects the posted read result |
| stall | output | 1 | Hold the pipeline this cycle |
| get_data | output | DATA_W | Most recent read result, zero-extended |
| slot_grant | input | 1 | This core's memory slot is in the current cycle |
| mem_strobe | output | 1 | Memory access in this cycle |
| mem_we | output | 1 | The access is a write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | DATA_W | Write word |
| mem_rdata | input | DATA_W | Read word, valid the cycle after a read strobe |

## Verification
The bench goes after back-to-back requests that arrive while the first is still waiting for its slot. A buffer that let the second request overwrite the first would send the wrong address or data to memory, or drop a store. It issues gets right after a read request, where a missing stall would hand back the previous read's data, and gets with nothing outstanding, where a needless stall would freeze the pipeline until the next slot. It writes every byte lane and both halves of a word and reads them back. An error in the merge step would corrupt the untouched lanes, and a wrong lane order would put bytes in swapped positions. The bench also checks that grants arriving while the buffer is empty cause no memory access.

// File: rtl/hpb_pkg.sv
`timescale 1ns/1ps
package hpb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_FULL = 2'd2,
    SZ_FULX = 2'd3
  } hpb_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DATA  = 2'd2,
    ST_MERGE = 2'd3
  } hpb_state_e;
endpackage

// File: rtl/hpb_lane.sv
`timescale 1ns/1ps
module hpb_lane #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = $clog2(DATA_W / 8)
) (
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] word_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [DATA_W-1:0] rd_ext,
  output logic [DATA_W-1:0] wr_merged
);
  import hpb_pkg::*;
  localparam int LANES = DATA_W / 8;

  logic [OFF_W-1:0] half_idx;
  assign half_idx = offset >> 1;

  // Read side: pick the addressed lane and zero-extend it.
  always_comb begin
    rd_ext = '0;
    case (size)
      SZ_BYTE: rd_ext[7:0]  = word_in[int'(offset) * 8 +: 8];
      SZ_HALF: rd_ext[15:0] = word_in[int'(half_idx) * 16 +: 16];
      default: rd_ext       = word_in;
    endcase
  end

  // Write side: each byte lane takes the new data or keeps the old word.
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic       take;
    logic [7:0] src;
    always_comb begin
      case (size)
        SZ_BYTE: begin
          take = (int'(offset) == b);
          src  = wdata_in[7:0];
        end
        SZ_HALF: begin
          take = (int'(half_idx) == (b / 2));
          src  = wdata_in[(b % 2) * 8 +: 8];
        end
        default: begin
          take = 1'b1;
          src  = wdata_in[b * 8 +: 8];
        end
      endcase
    end
    assign wr_merged[b * 8 +: 8] = take ? src : word_in[b * 8 +: 8];
  end
endmodule

// File: rtl/hpb_get_reg.sv
`timescale 1ns/1ps
module hpb_get_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/hpb_req_buf.sv
`timescale 1ns/1ps
module hpb_req_buf #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  logic                in_write,
  input  logic [1:0]          in_size,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [DATA_W-1:0]   in_wdata,
  input  logic                slot_grant,
  input  logic [DATA_W-1:0]   merged,
  output hpb_pkg::hpb_state_e state,
  output logic                op_write,
  output logic [1:0]          op_size,
  output logic [ADDR_W-1:0]   op_addr,
  output logic [DATA_W-1:0]   op_data,
  output logic                strobe,
  output logic                we,
  output logic                rd_done
);
  import hpb_pkg::*;

  logic full_word;
  assign full_word = op_size[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_write <= 1'b0;
      op_size  <= 2'd0;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          op_write <= in_write;
          op_size  <= in_size;
          op_addr  <= in_addr;
          op_data  <= in_wdata;
          state    <= ST_WAIT;
        end
        ST_WAIT: if (slot_grant)
          state <= (op_write && full_word) ? ST_IDLE : ST_DATA;
        ST_DATA: if (op_write) begin
          op_data <= merged;
          state   <= ST_MERGE;
        end else begin
          state <= ST_IDLE;
        end
        ST_MERGE: if (slot_grant) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe  = slot_grant && (state == ST_WAIT || state == ST_MERGE);
  assign we      = strobe && op_write && (state == ST_MERGE || full_word);
  assign rd_done = (state == ST_DATA) && !op_write;
endmodule

// File: rtl/hub_post_buf.sv
`timescale 1ns/1ps
module hub_post_buf #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  localparam int OFF_W   = $clog2(DATA_W / 8),
  localparam int WORD_AW = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               get_req,
  output logic               stall,
  output logic [DATA_W-1:0]  get_data,
  input  logic               slot_grant,
  output logic               mem_strobe,
  output logic               mem_we,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata
);
  import hpb_pkg::*;

  hpb_state_e        state;
  logic              op_write;
  logic [1:0]        op_size;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic [DATA_W-1:0] rd_ext;
  logic [DATA_W-1:0] merged;
  logic              rd_done;
  logic              busy;
  logic              rd_open;
  logic              accept;

  assign busy    = (state != ST_IDLE);
  assign rd_open = !op_write && (state == ST_WAIT || state == ST_DATA);
  assign accept  = req_valid && !busy;
  assign stall   = (req_valid && busy) || (get_req && rd_open);

  hpb_req_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .in_write   (req_write),
    .in_size    (req_size),
    .in_addr    (req_addr),
    .in_wdata   (req_wdata),
    .slot_grant (slot_grant),
    .merged     (merged),
    .state      (state),
    .op_write   (op_write),
    .op_size    (op_size),
    .op_addr    (op_addr),
    .op_data    (op_data),
    .strobe     (mem_strobe),
    .we         (mem_we),
    .rd_done    (rd_done)
  );

  hpb_lane #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_lane (
    .size      (op_size),
    .offset    (op_addr[OFF_W-1:0]),
    .word_in   (mem_rdata),
    .wdata_in  (op_data),
    .rd_ext    (rd_ext),
    .wr_merged (merged)
  );

  hpb_get_reg #(.DATA_W(DATA_W)) u_get (
    .clk  (clk),
    .rst  (rst),
    .load (rd_done),
    .din  (rd_ext),
    .dout (get_data)
  );

  assign mem_addr  = op_addr[ADDR_W-1:OFF_W];
  assign mem_wdata = op_data;
endmodule

// File: rtl/hub_post_buf_chk.sv
`timescale 1ns/1ps
module hub_post_buf_chk #(
  parameter int WORD_AW = 18,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               get_req,
  input logic               slot_grant,
  input logic               stall,
  input logic               mem_strobe,
  input logic               mem_we,
  input logic [WORD_AW-1:0] mem_addr,
  input logic [DATA_W-1:0]  get_data
);
  a_r10_strobe_in_slot: assert property (@(posedge clk) disable iff (rst)
    mem_strobe |-> slot_grant);

  a_r1_accept_quiet: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !stall) |-> !mem_strobe);

  a_r3_held_addr: assert property (@(posedge clk) disable iff (rst)
    (req_valid && stall) |=> $stable(mem_addr));

  a_r4_data_late: assert property (@(posedge clk) disable iff (rst)
    (mem_strobe && !mem_we) |=> $stable(get_data));

  a_r2_stall_cause: assert property (@(posedge clk) disable iff (rst)
    stall |-> (req_valid || get_req));
endmodule

bind hub_post_buf hub_post_buf_chk #(.WORD_AW(WORD_AW), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .get_req    (get_req),
  .slot_grant (slot_grant),
  .stall      (stall),
  .mem_strobe (mem_strobe),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .get_data   (get_data)
);

// File: tb/sim_hub_post_buf.sv
`timescale 1ns/1ps
module sim_hub_post_buf;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, get_req, slot_grant;
  logic [1:0]  req_size;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata, get_data, mem_wdata, mem_rdata;
  logic        stall, mem_strobe, mem_we;
  logic [5:0]  mem_addr;

  always #2.5 clk = ~clk;

  hub_post_buf #(.ADDR_W(AW), .DATA_W(32)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .get_req(get_req), .stall(stall), .get_data(get_data),
    .slot_grant(slot_grant), .mem_strobe(mem_strobe), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, waited;
  bit done = 0, last_stall;
  logic [31:0] mem [64];

  // reference model state
  int          ph = 0;          // 0 empty, 1 waiting slot, 2 data back, 3 write-back pending
  bit          o_wr;
  int          o_sz;
  logic [7:0]  o_addr;
  logic [31:0] o_wd, o_merged, m_get = 0, rd_drv = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] f_extract(int sz, int off, logic [31:0] w);
    if (sz == 0) return (w >> (8 * off)) & 32'hff;
    if (sz == 1) return (w >> (16 * (off / 2))) & 32'hffff;
    return w;
  endfunction

  function automatic logic [31:0] f_merge(int sz, int off, logic [31:0] old, logic [31:0] wd);
    logic [31:0] mask, val;
    if (sz >= 2) return wd;
    if (sz == 0) begin mask = 32'hff << (8 * off); val = (wd & 32'hff) << (8 * off); end
    else begin mask = 32'hffff << (16 * (off / 2)); val = (wd & 32'hffff) << (16 * (off / 2)); end
    return (old & ~mask) | (val & mask);
  endfunction

  task automatic step();
    bit e_stall, e_strb, e_we;
    logic [31:0] e_wd;
    logic [5:0]  e_addr;
    slot_grant = (cyc % 16 == 5);
    #1;
    e_stall = (req_valid && ph != 0) || (get_req && !o_wr && (ph == 1 || ph == 2));
    e_strb  = slot_grant && (ph == 1 || ph == 3);
    e_we    = e_strb && o_wr && (ph == 3 || o_sz >= 2);
    e_addr  = o_addr[7:2];
    e_wd    = (ph == 3) ? o_merged : o_wd;
    chk("R2", "stall", 32'(stall), 32'(e_stall));
    chk("R10", "mem_strobe", 32'(mem_strobe), 32'(e_strb));
    if (e_strb) begin
      chk("R7", "mem_we", 32'(mem_we), 32'(e_we));
      chk("R9", "mem_addr", 32'(mem_addr), 32'(e_addr));
    end
    if (e_we) chk("R6", "mem_wdata", mem_wdata, e_wd);
    chk("R8", "get_data", get_data, m_get);
    last_stall = e_stall;
    @(posedge clk);
    #1;
    case (ph)
      0: if (req_valid) begin
        o_wr = req_write; o_sz = int'(req_size); o_addr = req_addr; o_wd = req_wdata; ph = 1;
      end
      1: if (slot_grant) ph = (o_wr && o_sz >= 2) ? 0 : 2;
      2: if (o_wr) begin
        o_merged = f_merge(o_sz, int'(o_addr[1:0]), rd_drv, o_wd); ph = 3;
      end else begin
        m_get = f_extract(o_sz, int'(o_addr[1:0]), rd_drv); ph = 0;
      end
      default: if (slot_grant) ph = 0;
    endcase
    if (e_strb) begin
      if (e_we) mem[e_addr] = e_wd;
      else rd_drv = mem[e_addr];
    end
    mem_rdata = rd_drv;
    cyc++;
    @(negedge clk);
  endtask

  task automatic issue(bit wr, int sz, logic [7:0] a, logic [31:0] d);
    req_valid = 1; req_write = wr; req_size = 2'(sz); req_addr = a; req_wdata = d;
    waited = 0;
    forever begin
      step();
      if (!last_stall) break;
      waited++;
    end
    req_valid = 0;
  endtask

  task automatic get();
    get_req = 1;
    waited = 0;
    forever begin
      step();
      if (!last_stall) break;
      waited++;
    end
    get_req = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    rst = 1; req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0;
    get_req = 0; slot_grant = 0; mem_rdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk("R11", "stall after reset", 32'(stall), 0);
    chk("R11", "strobe after reset", 32'(mem_strobe), 0);
    chk("R11", "get_data after reset", get_data, 0);

    // R1 posted store; R2 back-to-back store stalls
    issue(1, 2, 8'h10, 32'hA1B2C3D4);
    chk("R1", "accept wait cycles", waited, 0);
    issue(1, 2, 8'h14, 32'h01020304);
    chk("R2", "second request stalled", 32'(waited > 0), 1);
    idle(3);
    // R4 split read with immediate get
    issue(0, 2, 8'h10, 0);
    get();
    chk("R4", "get stalled for data", 32'(waited > 0), 1);
    chk("R4", "full read", get_data, 32'hA1B2C3D4);
    // R5 get with nothing outstanding
    get();
    chk("R5", "no stall", waited, 0);
    chk("R5", "keeps last data", get_data, 32'hA1B2C3D4);
    // R7 byte stores on each lane, then half store
    issue(1, 0, 8'h20, 32'hFFFFFF11);
    issue(1, 0, 8'h21, 32'h00000022);
    issue(1, 0, 8'h22, 32'h00000033);
    issue(1, 0, 8'h23, 32'hAAAAAA44);
    issue(1, 1, 8'h16, 32'h1234BEEF);
    issue(0, 2, 8'h20, 0);
    get();
    chk("R7", "byte lanes merged", get_data, 32'h44332211);
    issue(0, 2, 8'h14, 0);
    get();
    chk("R7", "upper half merged", get_data, 32'hBEEF0304);
    // R8 sub-word reads
    issue(0, 0, 8'h23, 0);
    get();
    chk("R8", "byte lane 3", get_data, 32'h00000044);
    issue(0, 0, 8'h21, 0);
    get();
    chk("R8", "byte lane 1", get_data, 32'h00000022);
    issue(0, 1, 8'h12, 0);
    get();
    chk("R8", "upper half", get_data, 32'h0000A1B2);
    issue(0, 1, 8'h10, 0);
    get();
    chk("R8", "lower half", get_data, 32'h0000C3D4);
    // R9 size 3 is full word
    issue(0, 3, 8'h13, 0);
    get();
    chk("R9", "size 3 full read", get_data, 32'hA1B2C3D4);
    // R3 held store not overwritten by stalled one
    issue(1, 2, 8'h30, 32'hCAFEF00D);
    issue(1, 2, 8'h34, 32'h0BADBEEF);
    issue(0, 2, 8'h30, 0);
    get();
    chk("R3", "first store intact", get_data, 32'hCAFEF00D);
    issue(0, 2, 8'h34, 0);
    get();
    chk("R3", "second store intact", get_data, 32'h0BADBEEF);
    // R4 late get after data arrived: no stall
    issue(0, 0, 8'h22, 0);
    idle(24);
    get();
    chk("R4", "late get no stall", waited, 0);
    chk("R4", "late get data", get_data, 32'h00000033);
    // R10 grants while empty
    idle(40);
    chk("R10", "memory untouched word 0", mem[0], 0);

    done = 1;
    summary();
    $finish;
  end
endmodule